// File: doc/BRIEF.md
# Triggered Latency-Delayed Capture Controller

This block runs one single-shot acquisition for a front-end test bench. A host writes a start bit into a control register. The controller then sends a short train of trigger pulses and waits a programmable number of clock cycles. After that wait, it writes a programmable number of consecutive input samples into an on-chip buffer through a plain write port. When the last sample has been written, a completion flag rises in the same control register. The host polls that flag and reads the buffer back only once it is set.

Each cycle is self-timed. The latency and the sample count are copied when the cycle is accepted, so the host may rewrite them while a cycle is running. A start request that arrives while a cycle is active is dropped. The completion flag stays set until the next accepted start.

Top module: `acq_capture_ctrl`

## Requirements
- R1: After reset the controller is idle. The completion bit (control register bit 0) and the busy bit (control register bit 1) read 0. `trig_o` and `buf_we_o` are low. The latency register reads `LAT_INIT` and the count register reads `DEPTH-1`.
- R2: A host write to address 0 with data bit 0 set, made while idle, starts a cycle. From the next clock the busy bit reads 1 and the completion bit reads 0.
- R3: In the first 2*TRIG_PULSES cycles after the start is accepted, `trig_o` is high on cycles 0, 2, 4, and so on, and low on the odd cycles. It is low at all other times, so each pulse lasts one cycle.
- R4: After the trigger phase the controller waits L cycles, where L is the latency register value (address 1, bits LAT_W-1:0). A value of 0 behaves as 1. No buffer write happens during the wait.
- R5: After the wait, `buf_we_o` is high for exactly N consecutive cycles, where N is the count register value plus 1 (address 2, bits AW-1:0, AW = log2 DEPTH). `buf_addr_o` runs 0, 1, ..., N-1, and `buf_data_o` equals `sample_i` in the same cycle.
- R6: In the cycle after the last buffer write, the completion bit reads 1 and the busy bit still reads 1. One cycle later the busy bit reads 0.
- R7: A start write made while a cycle is active (busy bit 1) is ignored. The running cycle keeps its timing.
- R8: Latency or count writes made during an active cycle do not change that cycle. They do update the register readback.
- R9: Addresses 1 and 2 read back the last written latency and count values. Address 3 reads 0.
- R10: The completion bit stays at 1 until a start is accepted. A write to address 0 with bit 0 clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | HOST_W | Read data for `host_addr` (combinational) |
| trig_o | output | 1 | Trigger pulse train |
| sample_i | input | DATA_W | Sample data input |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | log2(DEPTH) | Buffer write address |
| buf_data_o | output | DATA_W | Buffer write data |

## Verification
The bench builds the block with DEPTH=16, LAT_W=4, TRIG_PULSES=2, DATA_W=8 and LAT_INIT=5. This small configuration lets the bench sweep every latency setting, including the zero case, and every sample count from 1 up to a full buffer. It checks the cycle-exact position of every trigger pulse and every buffer write in each run. Extra runs write a start, a latency value or a count value at chosen cycles inside an active cycle, and check that the running cycle is unaffected.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TRIGGER = 3'd1,
    ST_LATENCY = 3'd2,
    ST_RECORD  = 3'd3,
    ST_DONE    = 3'd4
  } acq_state_e;
endpackage

// File: rtl/acq_regs.sv
module acq_regs #(
  parameter int HOST_W   = 16,
  parameter int LAT_W    = 12,
  parameter int AW       = 9,
  parameter int LAT_INIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              start_req,
  input  logic              start_acc,
  input  logic              done_set,
  input  logic              busy,
  output logic [LAT_W-1:0]  lat_o,
  output logic [AW-1:0]     nm1_o,
  output logic              done_o
);
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [AW-1:0]    nm1_q, nm1_d;
  logic             done_q, done_d;
  logic             lat_en, nm1_en;

  assign start_req = host_wr && (host_addr == 2'd0) && host_wdata[0];
  assign lat_en    = host_wr && (host_addr == 2'd1);
  assign nm1_en    = host_wr && (host_addr == 2'd2);

  always_comb begin
    lat_d  = lat_en ? host_wdata[LAT_W-1:0] : lat_q;
    nm1_d  = nm1_en ? host_wdata[AW-1:0]    : nm1_q;
    done_d = done_q;
    if (start_acc)     done_d = 1'b0;
    else if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= LAT_W'(LAT_INIT);
      nm1_q  <= {AW{1'b1}};
      done_q <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      nm1_q  <= nm1_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      2'd0:    host_rdata[1:0]       = {busy, done_q};
      2'd1:    host_rdata[LAT_W-1:0] = lat_q;
      2'd2:    host_rdata[AW-1:0]    = nm1_q;
      default: host_rdata            = '0;
    endcase
  end

  assign lat_o  = lat_q;
  assign nm1_o  = nm1_q;
  assign done_o = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_acc) |=> done_q); // R10
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !done_q); // R2
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int LAT_W       = 12,
  parameter int AW          = 9,
  parameter int TRIG_PULSES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [AW-1:0]    nm1_i,
  output logic             start_acc,
  output logic             done_set,
  output logic             busy,
  output logic             trig,
  output logic             rec_en,
  output logic [AW-1:0]    rec_idx
);
  localparam int CW_A = (LAT_W > AW + 1) ? LAT_W : AW + 1;
  localparam int CW   = (CW_A > $clog2(2 * TRIG_PULSES) + 1) ? CW_A : $clog2(2 * TRIG_PULSES) + 1;
  localparam logic [CW-1:0] TRIG_LAST = CW'(2 * TRIG_PULSES - 1);

  acq_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LAT_W-1:0] lat_q;
  logic [AW-1:0]    nm1_q;
  logic [CW-1:0]    lat_last;
  logic             last;

  assign start_acc = start_req && (state_q == ST_IDLE);
  assign lat_last  = (lat_q == '0) ? '0 : CW'(lat_q) - CW'(1);

  always_comb begin
    case (state_q)
      ST_TRIGGER: last = (cnt_q == TRIG_LAST);
      ST_LATENCY: last = (cnt_q == lat_last);
      ST_RECORD:  last = (cnt_q == CW'(nm1_q));
      default:    last = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_acc) state_d = ST_TRIGGER;
      end
      ST_TRIGGER: if (last) begin state_d = ST_LATENCY; cnt_d = '0; end
      ST_LATENCY: if (last) begin state_d = ST_RECORD;  cnt_d = '0; end
      ST_RECORD:  if (last) begin state_d = ST_DONE;    cnt_d = '0; end
      default:    begin state_d = ST_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      nm1_q <= '0;
    end else if (start_acc) begin
      lat_q <= lat_i;
      nm1_q <= nm1_i;
    end
  end

  assign done_set = (state_q == ST_RECORD) && last;
  assign busy     = (state_q != ST_IDLE);
  assign trig     = (state_q == ST_TRIGGER) && !cnt_q[0];
  assign rec_en   = (state_q == ST_RECORD);
  assign rec_idx  = cnt_q[AW-1:0];

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_TRIGGER || cnt_q != '0)); // R7
  AST_TRIG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> trig); // R3
endmodule

// File: rtl/acq_wrport.sv
module acq_wrport #(
  parameter int DATA_W = 12,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_en,
  input  logic [AW-1:0]     rec_idx,
  input  logic              trig,
  input  logic [DATA_W-1:0] sample_i,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [DATA_W-1:0] buf_data_o
);
  assign buf_we_o   = rec_en;
  assign buf_addr_o = rec_idx;
  assign buf_data_o = sample_i;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we_o && $past(buf_we_o)) |-> (buf_addr_o == $past(buf_addr_o) + AW'(1))); // R5
  AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_we_o) |-> (buf_addr_o == '0)); // R5
  AST_NO_TRIG_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig && buf_we_o)); // R3
endmodule

// File: rtl/acq_capture_ctrl.sv
module acq_capture_ctrl #(
  parameter int DATA_W      = 12,
  parameter int LAT_W       = 12,
  parameter int DEPTH       = 512,
  parameter int TRIG_PULSES = 3,
  parameter int LAT_INIT    = 16,
  parameter int HOST_W      = 16,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              trig_o,
  input  logic [DATA_W-1:0] sample_i,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [DATA_W-1:0] buf_data_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             start_req, start_acc, done_set, busy, done;
  logic             rec_en, trig;
  logic [AW-1:0]    rec_idx, nm1;
  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  acq_regs #(.HOST_W(HOST_W), .LAT_W(LAT_W), .AW(AW), .LAT_INIT(LAT_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .start_req(start_req),
    .start_acc(start_acc), .done_set(done_set), .busy(busy),
    .lat_o(lat), .nm1_o(nm1), .done_o(done));

  acq_fsm #(.LAT_W(LAT_W), .AW(AW), .TRIG_PULSES(TRIG_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .start_req(start_req), .lat_i(lat), .nm1_i(nm1),
    .start_acc(start_acc), .done_set(done_set), .busy(busy), .trig(trig),
    .rec_en(rec_en), .rec_idx(rec_idx));

  acq_wrport #(.DATA_W(DATA_W), .AW(AW)) u_wrport (
    .clk(clk), .rst_n(rst_n_s), .rec_en(rec_en), .rec_idx(rec_idx), .trig(trig),
    .sample_i(sample_i), .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o),
    .buf_data_o(buf_data_o));

  assign trig_o = trig;

  AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(buf_we_o) |-> (done && busy)); // R6
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !busy) |-> (!trig_o && !buf_we_o)); // R6
endmodule

// File: tb/acq_capture_ctrl_bench.sv
module acq_capture_ctrl_bench;
  localparam int DATA_W = 8;
  localparam int LAT_W  = 4;
  localparam int DEPTH  = 16;
  localparam int TP     = 2;
  localparam int LINIT  = 5;
  localparam int HOST_W = 16;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_wr = 1'b0;
  logic [1:0]        host_addr = 2'd0;
  logic [HOST_W-1:0] host_wdata = '0;
  logic [HOST_W-1:0] host_rdata;
  logic              trig_o;
  logic [DATA_W-1:0] sample_i = '0;
  logic              buf_we_o;
  logic [AW-1:0]     buf_addr_o;
  logic [DATA_W-1:0] buf_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acq_capture_ctrl #(.DATA_W(DATA_W), .LAT_W(LAT_W), .DEPTH(DEPTH), .TRIG_PULSES(TP),
                     .LAT_INIT(LINIT), .HOST_W(HOST_W)) u_acq_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .trig_o(trig_o),
    .sample_i(sample_i), .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o),
    .buf_data_o(buf_data_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return DATA_W'((i * 37 + 5) & 8'hFF);
  endfunction

  // starts and ends at a negedge
  task automatic wr(input int a, input int d);
    host_wr = 1'b1; host_addr = 2'(a); host_wdata = HOST_W'(d);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    host_addr = 2'(a);
    #1;
    chk(req, int'(host_rdata), exp);
  endtask

  // one acquisition, optional host write on sequence cycle poke_at
  task automatic run_acq(input int lat, input int nm1, input int poke_at,
                         input int pa, input int pd);
    int l, n, tot;
    bit tw, ww;
    l = (lat == 0) ? 1 : lat;
    n = nm1 + 1;
    tot = 2 * TP + l + n;
    wr(1, lat);
    wr(2, nm1);
    wr(0, 1);
    rd("R2 busy after start", 0, 2);
    for (int i = 0; i < tot; i++) begin
      sample_i = pat(i);
      host_wr = (i == poke_at);
      if (i == poke_at) begin host_addr = 2'(pa); host_wdata = HOST_W'(pd); end
      #1;
      tw = (i < 2 * TP) && (i % 2 == 0);
      ww = (i >= 2 * TP + l);
      chk("R3 trigger pulse", int'(trig_o), int'(tw));
      chk(i < 2 * TP + l ? "R4 no write in wait" : "R5 write enable", int'(buf_we_o), int'(ww));
      if (ww) begin
        chk("R5 address", int'(buf_addr_o), i - 2 * TP - l);
        chk("R5 data", int'(buf_data_o), int'(pat(i)));
      end
      @(negedge clk);
      host_wr = 1'b0;
    end
    rd("R6 done and busy", 0, 3);
    chk("R6 no write after last", int'(buf_we_o), 0);
    @(negedge clk);
    rd("R6 done, idle", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    rd("R1 ctrl reset", 0, 0);
    rd("R1 latency reset", 1, LINIT);
    rd("R1 count reset", 2, DEPTH - 1);
    chk("R1 trig reset", int'(trig_o), 0);
    chk("R1 we reset", int'(buf_we_o), 0);
    rd("R9 addr3 zero", 3, 0);
    // R4 sweep every latency, including 0
    for (int lat = 0; lat < (1 << LAT_W); lat++) run_acq(lat, lat % DEPTH, -1, 0, 0);
    // R5 sweep every count
    for (int nm = 0; nm < DEPTH; nm++) run_acq(2, nm, -1, 0, 0);
    // R9 readback
    rd("R9 latency readback", 1, 2);
    rd("R9 count readback", 2, DEPTH - 1);
    // R10 write with bit0 clear keeps done
    wr(0, 2);
    rd("R10 done held", 0, 1);
    // R7 start during trigger and during record
    run_acq(3, 4, 1, 0, 1);
    run_acq(3, 4, 2 * TP + 3 + 1, 0, 1);
    // R8 config writes mid-cycle
    run_acq(4, 5, 2 * TP + 1, 1, 9);
    rd("R8 latency updated readback", 1, 9);
    host_addr = 2'd1; host_wdata = 16'd4; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    run_acq(4, 5, 2 * TP + 2, 2, 1);
    rd("R8 count updated readback", 2, 1);
    // R2 start clears done
    wr(0, 1);
    rd("R2 done cleared", 0, 2);
    repeat (2 * TP + 4 + 2 + 2) @(negedge clk);
    rd("R6 final idle", 0, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule